// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a simple host port and a 256K x 16 asynchronous DRAM whose 18-bit word address is sent in two 9-bit halves over one set of address pins. The host presents a word or byte read or write with an 18-bit word address, 16 bits of data and two byte enables. It holds the request until the controller pulses an acknowledge. For reads, the data arrives together with that pulse.

After an access, the controller leaves the row open. A later request to the same row is served with a column cycle alone, and RAS stays low. A request to another row first raises RAS for the precharge time. A timer schedules CAS-before-RAS refresh cycles. A pending refresh closes any open page and is served before the next host request. Every device timing is a parameter counted in controller clocks, so one build covers any speed grade.

Top module: `fpdram_ctrl`

## Requirements
- R1: While reset is held and right after it, RAS, both CAS strobes, WE and OE are high (inactive) and the acknowledge is low.
- R2: The row half (word address bits 17:9) is on the address pins in the cycle before RAS falls and in the cycle RAS falls. The column half (bits 8:0) is on the pins in the cycle before a CAS strobe falls and in the cycle it falls.
- R3: A word write pulls both CAS strobes low in the same cycle. WE is low for at least one cycle before CAS falls, OE stays high, and the write data is driven onto the data pins.
- R4: A byte write pulls only the strobe of the enabled byte low: enable bit 0 selects the lower CAS and data bits 7:0, and enable bit 1 selects the upper CAS and data bits 15:8. The other strobe stays high and the other byte in memory is unchanged.
- R5: A read pulls both CAS strobes low with WE high and OE low. The data pins are sampled in the last cycle of the CAS window, and the value is returned on the read data output in the cycle the acknowledge is high.
- R6: A request to the row that is still open is served without any new RAS falling edge.
- R7: A request to a different row raises RAS and keeps it high for at least T_RP cycles before the new row is opened.
- R8: One refresh becomes due every REF_INTERVAL cycles. Each refresh is a CAS-before-RAS cycle: both CAS strobes fall while RAS is high, and RAS falls only after that.
- R9: A due refresh closes an open page even when no host request is waiting. After the refresh, the next access to the previously open row opens that row again with a new RAS falling edge.
- R10: On a row opening, CAS falls exactly T_RCD cycles after RAS falls, and a column access holds CAS low for exactly T_CAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in bits 17:9, column in bits 8:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for writes (bit 0 low byte, bit 1 high byte) |
| req_ack | output | 1 | One-cycle pulse when the access completes |
| rsp_rdata | output | 16 | Read data, valid while req_ack is high after a read |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower byte column strobe, active low |
| dram_cash_n | output | 1 | Upper byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven toward the device |
| dram_dq_oe | output | 1 | High while dram_dq_out must drive the data pins |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
A corrupted open-row register or page flag shows up as a wrong RAS falling-edge count on the very next access. Either an extra row opening appears on a same-row request, or a missing one leaves data at the wrong row, and this is caught when the location is read back. A wrong sequencer state or counter shows up within one access as a changed RAS-to-CAS distance, a changed CAS width, or a strobe edge arriving together with an address change. A lost refresh request shows up as a shortfall in the refresh count over a few intervals.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;

    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int BE_W   = 2;
    localparam int ADDR_W = ROW_W + COL_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_OPEN,
        ST_PRE,
        ST_RF_CSR,
        ST_RF_RAS
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
    } host_req_t;

    typedef struct packed {
        logic ras_n;
        logic casl_n;
        logic cash_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:COL_W];
    endfunction

    function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

    // Reads fetch the whole word; writes strobe only the enabled bytes.
    function automatic logic [BE_W-1:0] cas_select(input host_req_t r);
        return r.write ? r.be : {BE_W{1'b1}};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpd_refresh_timer.sv
module fpd_refresh_timer #(
    parameter int REF_INTERVAL = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic pending
);
    localparam int TW = $clog2(REF_INTERVAL);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= TW'(REF_INTERVAL - 1);
            pending <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q   <= TW'(REF_INTERVAL - 1);
            pending <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (grant) pending <= 1'b0;
        end
    end

    // R8: a due refresh is never dropped before the sequencer takes it.
    a_r8_pending_kept: assert property (@(posedge clk) disable iff (rst)
        (pending && !grant) |=> pending);

    // R8: the sequencer only takes a refresh that is due.
    a_r8_grant_needs_pending: assert property (@(posedge clk) disable iff (rst)
        grant |-> pending);

endmodule

// File: rtl/fpd_page_tracker.sv
module fpd_page_tracker
    import fpdram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             open_set,
    input  logic [ROW_W-1:0] set_row,
    input  logic             open_clr,
    input  logic [ROW_W-1:0] req_row,
    output logic             row_open,
    output logic             page_hit
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            row_q    <= '0;
        end else if (open_set) begin
            row_open <= 1'b1;
            row_q    <= set_row;
        end else if (open_clr) begin
            row_open <= 1'b0;
        end
    end

    assign page_hit = row_open && (req_row == row_q);

    // R6/R7: a page is never opened and closed in the same cycle.
    a_r7_set_clr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(open_set && open_clr));

    // R7: a row is opened only from the closed state.
    a_r7_open_from_closed: assert property (@(posedge clk) disable iff (rst)
        open_set |-> !row_open);

endmodule

// File: rtl/fpd_sequencer.sv
module fpd_sequencer
    import fpdram_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_CAS = 2,
    parameter int T_RP  = 3,
    parameter int T_CSR = 1,
    parameter int T_RFH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  host_req_t         req_in,
    input  logic              page_hit,
    input  logic              ref_pending,
    output logic              ref_grant,
    output logic              open_set,
    output logic [ROW_W-1:0]  open_row,
    output logic              open_clr,
    output strobe_t           strb,
    output logic [ROW_W-1:0]  addr_out,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int T_MAX = max_of(max_of(T_RCD, T_CAS), max_of(max_of(T_RP, T_CSR), T_RFH));
    localparam int CNT_W = $clog2(T_MAX + 1);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    host_req_t         cur_q, cur_d;
    logic              ack_d;
    logic [BE_W-1:0]   sel;
    logic              last;

    assign last = (cnt_q == '0);
    assign sel  = cas_select(cur_q);

    // Next-state and counter loading.
    always_comb begin
        state_d   = state_q;
        cnt_d     = last ? '0 : cnt_q - 1'b1;
        cur_d     = cur_q;
        ack_d     = 1'b0;
        ref_grant = 1'b0;
        open_set  = 1'b0;
        open_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d   = ST_RF_CSR;
                    cnt_d     = CNT_W'(T_CSR - 1);
                    ref_grant = 1'b1;
                end else if (req_valid) begin
                    state_d = ST_ROW;
                    cur_d   = req_in;
                end
            end
            ST_ROW: begin
                state_d  = ST_RCD;
                cnt_d    = CNT_W'(T_RCD - 1);
                open_set = 1'b1;
            end
            ST_RCD: if (last) begin
                state_d = ST_CAS;
                cnt_d   = CNT_W'(T_CAS - 1);
            end
            ST_COL: begin
                state_d = ST_CAS;
                cnt_d   = CNT_W'(T_CAS - 1);
            end
            ST_CAS: if (last) begin
                state_d = ST_OPEN;
                ack_d   = 1'b1;
            end
            ST_OPEN: begin
                if (ref_pending || (req_valid && !page_hit)) begin
                    state_d  = ST_PRE;
                    cnt_d    = CNT_W'(T_RP - 1);
                    open_clr = 1'b1;
                end else if (req_valid) begin
                    state_d = ST_COL;
                    cur_d   = req_in;
                end
            end
            ST_PRE: if (last) state_d = ST_IDLE;
            ST_RF_CSR: if (last) begin
                state_d = ST_RF_RAS;
                cnt_d   = CNT_W'(T_RFH - 1);
            end
            ST_RF_RAS: if (last) begin
                state_d = ST_PRE;
                cnt_d   = CNT_W'(T_RP - 1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            ack     <= 1'b0;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cur_q   <= cur_d;
            ack     <= ack_d;
            if (state_q == ST_CAS && last && !cur_q.write) rdata <= dq_in;
        end
    end

    // Pin decode from the registered state.
    always_comb begin
        strb     = '{ras_n: 1'b1, casl_n: 1'b1, cash_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        addr_out = row_of(cur_q.addr);
        dq_oe    = 1'b0;
        unique case (state_q)
            ST_RCD: begin
                strb.ras_n = 1'b0;
                strb.we_n  = !cur_q.write;
                dq_oe      = cur_q.write;
                // Row held through the RAS edge, column from the next cycle.
                if (cnt_q != CNT_W'(T_RCD - 1)) addr_out = col_of(cur_q.addr);
            end
            ST_COL: begin
                strb.ras_n = 1'b0;
                strb.we_n  = !cur_q.write;
                dq_oe      = cur_q.write;
                addr_out   = col_of(cur_q.addr);
            end
            ST_CAS: begin
                strb.ras_n  = 1'b0;
                strb.casl_n = !sel[0];
                strb.cash_n = !sel[1];
                strb.we_n   = !cur_q.write;
                strb.oe_n   = cur_q.write;
                dq_oe       = cur_q.write;
                addr_out    = col_of(cur_q.addr);
            end
            ST_OPEN: begin
                strb.ras_n = 1'b0;
                addr_out   = col_of(cur_q.addr);
            end
            ST_RF_CSR: begin
                strb.casl_n = 1'b0;
                strb.cash_n = 1'b0;
            end
            ST_RF_RAS: begin
                strb.ras_n  = 1'b0;
                strb.casl_n = 1'b0;
                strb.cash_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign dq_out   = cur_q.wdata;
    assign open_row = row_of(cur_q.addr);

    // R2: address does not move in the cycle RAS falls.
    a_r2_row_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> $stable(addr_out));

    // R2: address does not move when a column strobe falls under an open row.
    a_r2_col_setup: assert property (@(posedge clk) disable iff (rst)
        (!strb.ras_n && ($fell(strb.casl_n) || $fell(strb.cash_n))) |-> $stable(addr_out));

    // R3: early write, WE already low in the cycle before CAS falls.
    a_r3_early_write: assert property (@(posedge clk) disable iff (rst)
        (!strb.ras_n && !strb.we_n && ($fell(strb.casl_n) || $fell(strb.cash_n)))
            |-> $past(!strb.we_n));

    // R3: output enable stays off and the data pins are driven while writing.
    a_r3_oe_off_on_write: assert property (@(posedge clk) disable iff (rst)
        !strb.we_n |-> (strb.oe_n && dq_oe));

    // R5: reads strobe both bytes together.
    a_r5_read_pair: assert property (@(posedge clk) disable iff (rst)
        (!strb.oe_n) |-> (!strb.casl_n && !strb.cash_n && strb.we_n));

    // R7: RAS stays high for more than one cycle after it rises.
    a_r7_precharge: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |=> strb.ras_n);

    // R8: a refresh RAS edge is always preceded by both CAS strobes low.
    a_r8_cbr_order: assert property (@(posedge clk) disable iff (rst)
        ($fell(strb.ras_n) && !strb.casl_n) |-> $past(!strb.casl_n && !strb.cash_n));

    // R5: the acknowledge is a single-cycle pulse.
    a_r5_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
    import fpdram_pkg::*;
#(
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_CSR        = 1,
    parameter int T_RFH        = 4,
    parameter int REF_INTERVAL = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_casl_n,
    output logic              dram_cash_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    host_req_t        hreq;
    strobe_t          strb;
    logic             ref_pending, ref_grant;
    logic             open_set, open_clr, row_open, page_hit;
    logic [ROW_W-1:0] open_row;

    assign hreq = '{write: req_write, addr: req_addr, wdata: req_wdata, be: req_be};

    fpd_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .grant   (ref_grant),
        .pending (ref_pending)
    );

    fpd_page_tracker u_page (
        .clk      (clk),
        .rst      (rst),
        .open_set (open_set),
        .set_row  (open_row),
        .open_clr (open_clr),
        .req_row  (row_of(req_addr)),
        .row_open (row_open),
        .page_hit (page_hit)
    );

    fpd_sequencer #(
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_RP  (T_RP),
        .T_CSR (T_CSR),
        .T_RFH (T_RFH)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_in      (hreq),
        .page_hit    (page_hit),
        .ref_pending (ref_pending),
        .ref_grant   (ref_grant),
        .open_set    (open_set),
        .open_row    (open_row),
        .open_clr    (open_clr),
        .strb        (strb),
        .addr_out    (dram_addr),
        .dq_out      (dram_dq_out),
        .dq_oe       (dram_dq_oe),
        .dq_in       (dram_dq_in),
        .ack         (req_ack),
        .rdata       (rsp_rdata)
    );

    assign dram_ras_n  = strb.ras_n;
    assign dram_casl_n = strb.casl_n;
    assign dram_cash_n = strb.cash_n;
    assign dram_we_n   = strb.we_n;
    assign dram_oe_n   = strb.oe_n;

    // R6: the page flag and the RAS pin agree outside the refresh window.
    a_r6_open_means_ras_low: assert property (@(posedge clk) disable iff (rst)
        (row_open && dram_casl_n) |-> !dram_ras_n);

    // R1: strobes are inactive in the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n && !req_ack));

endmodule

// File: tb/tb_fpdram_ctrl.sv
module tb_fpdram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 3, T_CAS = 2, T_RP = 3, T_CSR = 1, T_RFH = 4;
    localparam int REF_INTERVAL = 300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
    logic [8:0]  addr;
    logic [15:0] dq_out, dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpdram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR),
                  .T_RFH(T_RFH), .REF_INTERVAL(REF_INTERVAL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

    // ---------------- behavioural memory and pin monitor ----------------
    logic [15:0] mem [int unsigned];
    logic [15:0] rd_word = 16'h0;
    logic [8:0]  row_lat = '0;
    int ras_falls = 0, refreshes = 0, cbr_err = 0, setup_err = 0, ew_err = 0;
    int read_err = 0, upper_falls = 0, lower_falls = 0;
    int ncyc = 0, ras_fall_at = 0, last_rcd = -1, cas_run = 0, last_cas_len = -1;
    int high_run = 0, last_high = -1;
    logic p_ras = 1, p_casl = 1, p_cash = 1, p_we = 1;
    logic [8:0] p_addr = '0;
    logic first_col = 0;

    assign dq_in = (!oe_n && (!casl_n || !cash_n)) ? rd_word : 16'hBAD0;

    always @(negedge clk) begin
        if (!rst) begin
            int unsigned key;
            logic [15:0] w;
            ncyc++;
            if (ras_n) high_run++;
            if (p_ras && !ras_n) begin
                if (!casl_n && !cash_n) refreshes++;
                else if (!casl_n || !cash_n) cbr_err++;
                else begin
                    ras_falls++;
                    row_lat     = addr;
                    ras_fall_at = ncyc;
                    first_col   = 1;
                    last_high   = high_run;
                end
                if (addr != p_addr) setup_err++;
            end
            if (!ras_n) high_run = 0;
            if (!ras_n && ((p_casl && !casl_n) || (p_cash && !cash_n))) begin
                if (addr != p_addr) setup_err++;
                if (first_col) begin
                    last_rcd  = ncyc - ras_fall_at;
                    first_col = 0;
                end
                key = {14'd0, row_lat, addr};
                if (!we_n) begin
                    if (p_we || !oe_n || !dq_oe) ew_err++;
                    w = mem.exists(key) ? mem[key] : 16'h0;
                    if (p_casl && !casl_n) begin w[7:0] = dq_out[7:0]; lower_falls++; end
                    if (p_cash && !cash_n) begin w[15:8] = dq_out[15:8]; upper_falls++; end
                    mem[key] = w;
                end else begin
                    if (oe_n || casl_n != cash_n) read_err++;
                    rd_word = mem.exists(key) ? mem[key] : 16'h0;
                end
            end
            if (!ras_n && (!casl_n || !cash_n)) cas_run++;
            else if (cas_run != 0) begin
                last_cas_len = cas_run;
                cas_run = 0;
            end
            p_ras = ras_n; p_casl = casl_n; p_cash = cash_n; p_we = we_n; p_addr = addr;
        end
    end

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        forever begin
            @(negedge clk);
            if (req_ack) break;
        end
        rd = rsp_rdata;
        req_valid = 0;
    endtask

    task automatic wait_refresh();
        int r0 = refreshes;
        for (int i = 0; i < 2 * REF_INTERVAL && refreshes == r0; i++) @(negedge clk);
        repeat (T_RP + 4) @(negedge clk);
    endtask

    function automatic logic [17:0] wa(input int r, input int c);
        return {r[8:0], c[8:0]};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(ras_n && casl_n && cash_n && we_n && oe_n, "R1 strobes idle in reset",
            {ras_n, casl_n, cash_n, we_n, oe_n}, 5'h1f);
        rst = 0;
        @(negedge clk);
        chk(ras_n && casl_n && cash_n && we_n && oe_n && !req_ack, "R1 strobes idle after reset",
            {req_ack, ras_n, casl_n, cash_n, we_n, oe_n}, 6'h1f);
    endtask

    task automatic t_word_rw();
        logic [15:0] rd;
        wait_refresh();
        access(1, wa(5, 7), 16'h1234, 2'b11, rd);
        chk(row_lat == 9'd5, "R2 row latched at RAS", row_lat, 5);
        chk(last_rcd == T_RCD, "R10 RAS-to-CAS cycles", last_rcd, T_RCD);
        chk(ew_err == 0, "R3 early write with OE high", ew_err, 0);
        access(0, wa(5, 7), 16'h0, 2'b11, rd);
        chk(rd == 16'h1234, "R5 read returns word", rd, 16'h1234);
        chk(last_cas_len == T_CAS, "R10 CAS width", last_cas_len, T_CAS);
        chk(read_err == 0, "R5 read strobes", read_err, 0);
        access(1, wa(5, 8), 16'hA55A, 2'b11, rd);
        access(0, wa(5, 8), 16'h0, 2'b11, rd);
        chk(rd == 16'hA55A, "R3 second word pattern", rd, 16'hA55A);
        chk(setup_err == 0, "R2 address stable at strobe edges", setup_err, 0);
    endtask

    task automatic t_byte();
        logic [15:0] rd;
        int u0, l0;
        access(1, wa(12, 3), 16'hFFFF, 2'b11, rd);
        u0 = upper_falls; l0 = lower_falls;
        access(1, wa(12, 3), 16'h00AB, 2'b01, rd);
        chk(upper_falls == u0 && lower_falls == l0 + 1, "R4 low byte write strobes only lower CAS",
            upper_falls - u0, 0);
        access(0, wa(12, 3), 16'h0, 2'b11, rd);
        chk(rd == 16'hFFAB, "R4 low byte write keeps high byte", rd, 16'hFFAB);
        l0 = lower_falls;
        access(1, wa(12, 3), 16'hCD00, 2'b10, rd);
        chk(lower_falls == l0, "R4 high byte write leaves lower CAS high", lower_falls - l0, 0);
        access(0, wa(12, 3), 16'h0, 2'b11, rd);
        chk(rd == 16'hCDAB, "R4 high byte write keeps low byte", rd, 16'hCDAB);
    endtask

    task automatic t_page_hit();
        logic [15:0] rd;
        int f0;
        wait_refresh();
        access(1, wa(20, 1), 16'h1111, 2'b11, rd);
        f0 = ras_falls;
        access(1, wa(20, 2), 16'h2222, 2'b11, rd);
        access(0, wa(20, 1), 16'h0, 2'b11, rd);
        chk(rd == 16'h1111, "R6 page hit read data", rd, 16'h1111);
        access(0, wa(20, 2), 16'h0, 2'b11, rd);
        chk(rd == 16'h2222, "R6 page hit second column", rd, 16'h2222);
        chk(ras_falls == f0, "R6 no RAS edge on page hits", ras_falls - f0, 0);
    endtask

    task automatic t_page_miss();
        logic [15:0] rd;
        int f0;
        wait_refresh();
        access(1, wa(30, 4), 16'h3333, 2'b11, rd);
        f0 = ras_falls;
        access(1, wa(31, 4), 16'h4444, 2'b11, rd);
        chk(ras_falls == f0 + 1, "R7 miss opens a new row", ras_falls - f0, 1);
        chk(last_high >= T_RP, "R7 precharge length", last_high, T_RP);
        chk(row_lat == 9'd31, "R2 new row on pins", row_lat, 31);
        access(0, wa(30, 4), 16'h0, 2'b11, rd);
        chk(rd == 16'h3333, "R7 old row intact", rd, 16'h3333);
    endtask

    task automatic t_refresh_rate();
        int r0;
        r0 = refreshes;
        repeat (10 * REF_INTERVAL) @(negedge clk);
        chk(refreshes - r0 >= 9 && refreshes - r0 <= 11, "R8 refresh count over ten intervals",
            refreshes - r0, 10);
        chk(cbr_err == 0, "R8 CAS before RAS ordering", cbr_err, 0);
    endtask

    task automatic t_refresh_priority();
        logic [15:0] rd;
        int f0, r0;
        wait_refresh();
        access(1, wa(9, 1), 16'h9999, 2'b11, rd);
        f0 = ras_falls; r0 = refreshes;
        wait_refresh();
        chk(refreshes > r0, "R9 refresh taken with page open", refreshes - r0, 1);
        access(0, wa(9, 1), 16'h0, 2'b11, rd);
        chk(ras_falls == f0 + 1, "R9 row reopened after refresh", ras_falls - f0, 1);
        chk(rd == 16'h9999, "R9 data after refresh", rd, 16'h9999);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_word_rw();
        t_byte();
        t_page_hit();
        t_page_miss();
        t_refresh_rate();
        t_refresh_priority();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule